// File: doc/BRIEF.md
# Boundary-Scan Cell Chain for Bidirectional Pins

This block places a boundary-scan cell group between the core logic and each of N bidirectional pads. Every group holds three capture flops and three update flops. The capture flops sample the core's output data, the core's output enable and the pad's input value. The update flops hold the values that test mode drives onto the pad and back into the core. The capture flops of all groups form one serial register. It runs from `sdi` through every cell to `sdo`, so a test controller can load a pattern, apply it to the pins and read back what the pins and the core present.

The design uses a single clock, `clk`. The shift/capture strobe `cap_en` and the update strobe `upd_en` are synchronous enables that the test controller asserts for one cycle per scan clock or update event. Because the update flops load only on `upd_en`, the pads stay stable while a new pattern shifts in. The `test_mode` input selects what drives the pad and the core input: update-register data or normal functional data. A global `highz` input turns every pad driver off, whatever the other controls are doing.

Top module: `bscan_io_chain`

## Requirements
- R1: While `rst_n` is low, all capture and update flops clear asynchronously. After reset, `sdo` is 0, and in test mode `pad_out`, `pad_oe` and `core_in` are all 0.
- R2: When `test_mode` is 0 and `highz` is 0, `pad_out` equals `core_out`, `pad_oe` equals `core_oe`, and `core_in` equals `pad_in`, bit for bit and without delay.
- R3: When `highz` is 1, every bit of `pad_oe` is 0, in both functional and test mode.
- R4: A clock edge with `cap_en`=1 and `shift`=0 loads each cell i's capture flops: the input flop from `pad_in[i]`, the enable flop from `core_oe[i]` and the output flop from `core_out[i]`. `sdo` then shows `core_out[N-1]`.
- R5: A clock edge with `cap_en`=1 and `shift`=1 moves the serial register one place. The serial order is `sdi`, then for cell 0, 1, …, N-1 in turn its input flop, enable flop and output flop. `sdo` is the output flop of cell N-1. A capture therefore shifts out as `core_out[N-1]`, `core_oe[N-1]`, `pad_in[N-1]`, `core_out[N-2]`, … `pad_in[0]`.
- R6: A clock edge with `cap_en`=0 leaves the capture flops unchanged, whatever the values of `shift` and `sdi`.
- R7: A clock edge with `upd_en`=1 copies every capture flop into its update flop. In test mode, with `highz`=0, cell i then drives `pad_out[i]` from its output update flop, `pad_oe[i]` from its enable update flop and `core_in[i]` from its input update flop.
- R8: Without `upd_en`, the update flops hold, so in test mode `pad_out`, `pad_oe` and `core_in` stay constant through shifting and capture.
- R9: In test mode, changes on `core_out`, `core_oe` and `pad_in` do not reach `pad_out`, `pad_oe` or `core_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial scan data into cell 0 |
| shift | input | 1 | 1 selects shifting, 0 selects parallel capture |
| cap_en | input | 1 | Scan clock strobe for the capture flops |
| upd_en | input | 1 | Update strobe for the update flops |
| test_mode | input | 1 | 1 lets the update flops drive the pads and the core input |
| highz | input | 1 | Forces every pad output enable to 0 |
| core_out | input | N | Output data from the core, one bit per pin |
| core_oe | input | N | Output enable from the core, one bit per pin |
| core_in | output | N | Input data to the core, one bit per pin |
| pad_out | output | N | Data to the pad drivers |
| pad_oe | output | N | Enable to the pad drivers |
| pad_in | input | N | Value received from each pad |
| sdo | output | 1 | Serial scan data out of cell N-1 |

## Verification
The bench captures distinct patterns and shifts them all the way out to test the serial order. A cell that swapped its input and enable flops, or chained cells in reverse, would return the bits in the wrong positions. It loads a pattern without updating and checks that the pads keep their old values. A design that let the update flops follow the capture flops would make the pins toggle during shifting. It also holds `cap_en` low while `shift` and `sdi` toggle, which catches a design that shifts on every clock. Finally, it raises `highz` in both modes to catch an override that was applied before the mode select instead of after it.

// File: rtl/bscan_io_chain.sv
module bscan_io_chain #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sdi,
  input  logic         shift,
  input  logic         cap_en,
  input  logic         upd_en,
  input  logic         test_mode,
  input  logic         highz,
  input  logic [N-1:0] core_out,
  input  logic [N-1:0] core_oe,
  output logic [N-1:0] core_in,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe,
  input  logic [N-1:0] pad_in,
  output logic         sdo
);
  localparam int W = 3 * N;

  logic [W-1:0] cap_q, upd_q, par_d;

  for (genvar i = 0; i < N; i++) begin : g_cell
    assign par_d[3*i]   = pad_in[i];
    assign par_d[3*i+1] = core_oe[i];
    assign par_d[3*i+2] = core_out[i];

    assign pad_out[i] = test_mode ? upd_q[3*i+2] : core_out[i];
    assign pad_oe[i]  = !highz && (test_mode ? upd_q[3*i+1] : core_oe[i]);
    assign core_in[i] = test_mode ? upd_q[3*i] : pad_in[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= shift ? {cap_q[W-2:0], sdi} : par_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      upd_q <= '0;
    else if (upd_en) upd_q <= cap_q;

  assign sdo = cap_q[W-1];
endmodule

// File: rtl/bscan_io_chain_chk.sv
module bscan_io_chain_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         shift,
  input logic         cap_en,
  input logic         upd_en,
  input logic         test_mode,
  input logic         highz,
  input logic [N-1:0] core_out,
  input logic [N-1:0] pad_out,
  input logic [N-1:0] pad_oe,
  input logic         sdo
);
  // R3
  highz_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    highz |-> (pad_oe == '0));

  // R6
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(sdo));

  // R4
  capture_to_sdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !shift) |=> (sdo == $past(core_out[N-1])));

  // R8
  pad_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !upd_en) |=> (!test_mode || $stable(pad_out)));

  // R8
  oe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !upd_en && !highz) |=> (!test_mode || highz || $stable(pad_oe)));
endmodule

bind bscan_io_chain bscan_io_chain_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift(shift), .cap_en(cap_en), .upd_en(upd_en),
  .test_mode(test_mode), .highz(highz), .core_out(core_out),
  .pad_out(pad_out), .pad_oe(pad_oe), .sdo(sdo)
);

// File: tb/bscan_io_chain_tb.sv
module bscan_io_chain_tb;
  localparam int N = 4;
  localparam int W = 3 * N;

  logic clk = 0, rst_n = 0;
  logic sdi = 0, shift = 0, cap_en = 0, upd_en = 0, test_mode = 0, highz = 0;
  logic [N-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic [N-1:0] core_in, pad_out, pad_oe;
  logic sdo;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  bscan_io_chain #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .shift(shift), .cap_en(cap_en),
    .upd_en(upd_en), .test_mode(test_mode), .highz(highz),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in), .sdo(sdo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_test_pads(input string req, input logic [W-1:0] v);
    logic [N-1:0] eo, ee, ei;
    for (int i = 0; i < N; i++) begin
      eo[i] = v[3*i+2]; ee[i] = v[3*i+1]; ei[i] = v[3*i];
    end
    chk({req, " pad_out"}, 32'(pad_out), 32'(eo));
    chk({req, " pad_oe"},  32'(pad_oe),  32'(ee));
    chk({req, " core_in"}, 32'(core_in), 32'(ei));
  endtask

  task automatic t_reset;
    rst_n = 0; test_mode = 1;
    repeat (2) @(negedge clk);
    chk("R1 sdo", 32'(sdo), 0);
    chk_test_pads("R1", '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 sdo after release", 32'(sdo), 0);
    test_mode = 0;
  endtask

  task automatic t_functional;
    logic [N-1:0] pats [3] = '{4'hA, 4'h5, 4'hC};
    test_mode = 0; highz = 0;
    for (int k = 0; k < 3; k++) begin
      core_out = pats[k]; core_oe = ~pats[(k+1)%3]; pad_in = pats[(k+2)%3];
      #1;
      chk("R2 pad_out", 32'(pad_out), 32'(core_out));
      chk("R2 pad_oe",  32'(pad_oe),  32'(core_oe));
      chk("R2 core_in", 32'(core_in), 32'(pad_in));
    end
  endtask

  task automatic shift_in(input logic [W-1:0] v, input logic [W-1:0] hold);
    for (int k = W - 1; k >= 0; k--) begin
      @(negedge clk);
      if (test_mode) chk_test_pads("R8 during shift", hold);
      sdi = v[k]; shift = 1; cap_en = 1;
    end
    @(negedge clk);
    cap_en = 0; shift = 0;
  endtask

  task automatic do_update;
    @(negedge clk); upd_en = 1;
    @(negedge clk); upd_en = 0;
  endtask

  task automatic t_capture_shift_out(input logic [N-1:0] o, input logic [N-1:0] e,
                                     input logic [N-1:0] p);
    logic [W-1:0] exp;
    for (int i = 0; i < N; i++) begin
      exp[3*i+2] = o[i]; exp[3*i+1] = e[i]; exp[3*i] = p[i];
    end
    core_out = o; core_oe = e; pad_in = p;
    @(negedge clk); shift = 0; cap_en = 1;
    @(negedge clk); shift = 1;
    for (int k = W - 1; k >= 0; k--) begin
      chk($sformatf("R4 R5 sdo bit %0d", k), 32'(sdo), 32'(exp[k]));
      @(negedge clk);
    end
    cap_en = 0; shift = 0;
  endtask

  task automatic t_update(input logic [W-1:0] v);
    test_mode = 1;
    shift_in(v, '0);
    do_update;
    chk_test_pads("R7", v);
  endtask

  task automatic t_hold;
    logic [W-1:0] v = 12'h6D3;
    shift_in(v, 12'hA5C);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); cap_en = 0; shift = 1; sdi = k[0];
    end
    @(negedge clk); shift = 0;
    chk("R6 sdo held", 32'(sdo), 32'(v[W-1]));
    chk_test_pads("R8 before update", 12'hA5C);
    do_update;
    chk_test_pads("R6 chain intact", v);
  endtask

  task automatic t_isolation;
    logic [W-1:0] cur = 12'h6D3;
    core_out = ~core_out; core_oe = ~core_oe; pad_in = ~pad_in;
    #1 chk_test_pads("R9 core and pad change", cur);
    @(negedge clk); shift = 0; cap_en = 1;
    @(negedge clk); cap_en = 0;
    chk_test_pads("R8 after capture", cur);
  endtask

  task automatic t_highz;
    highz = 1; #1;
    chk("R3 test mode", 32'(pad_oe), 0);
    test_mode = 0; core_oe = '1; #1;
    chk("R3 functional", 32'(pad_oe), 0);
    chk("R3 pad_out unaffected", 32'(pad_out), 32'(core_out));
    highz = 0; #1;
    chk("R2 oe after highz", 32'(pad_oe), 32'(core_oe));
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset;
    t_functional;
    t_capture_shift_out(4'b1011, 4'b0110, 4'b1100);
    t_capture_shift_out(4'b0100, 4'b1001, 4'b0011);
    t_update(12'hA5C);
    t_hold;
    t_isolation;
    t_highz;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule